// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor's load/store port and a slower main memory. It keeps a small table of lines. Each line holds one 32-bit word, a valid flag and the upper address bits (the tag) of the word it currently mirrors. A word's line is chosen by its word address modulo the number of lines. Every memory word therefore has exactly one place it can live, and words that share that place displace each other.

A read that finds its word answers in the same cycle, with no memory traffic. A read that misses holds the processor stalled and fetches the word over a request/acknowledge memory port whose latency varies. It installs the word, then lets the access finish as a hit. Every write goes through to memory. A write to an absent word first fetches and installs that word. Then the new value goes both to the line and to memory. The processor keeps its request steady while the stall output is high. The access completes on the first clock edge at which the stall output is low.

Top module: `dmcache`

## Requirements
- R1: After reset every line is invalid, so the first read of any address stalls and issues a memory read.
- R2: A read whose line is valid with a matching tag returns the stored word in the same cycle, with stall low and no memory request.
- R3: A read miss issues one memory read (mem_we=0) of the word, installs the returned data, and completes in the cycle after the acknowledge, returning that data; with a memory latency of L extra cycles the processor sees 3+L stall cycles.
- R4: The line index is bits [IDX_W+1:2] of the address (word address modulo LINES); two words with equal index and different tags evict each other.
- R5: A write hit issues one memory write (mem_we=1) carrying the new data, updates the line, and completes in the cycle after the acknowledge (3+L stall cycles). A later read of that word hits and returns the new value.
- R6: A write miss first reads the word from memory, then issues the memory write, and the line ends holding the written data (5+2L stall cycles).
- R7: The stall output stays high from miss detection until the final acknowledge of the access has been taken, for any memory latency.
- R8: Address bits [1:0] are ignored: any byte address within a resident word hits that word, and mem_addr[1:0] is always zero.
- R9: While mem_req is high without mem_ack, the next cycle keeps mem_req high with the same mem_addr, mem_we and mem_wdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until stall is low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid when a read completes |
| cpu_stall | output | 1 | High while the access cannot complete |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the memory transaction |

## Verification
The bench targets index conflicts. If the tag were compared too narrowly, or the index were taken from the wrong bits, the second of two aliasing addresses would be served the first one's word. It exercises write misses, where a design that skipped the fill or wrote memory before filling would show the wrong order or count of memory transactions. Byte-offset addresses are tried against a resident word; a design that decoded the low bits would miss or send an unaligned memory address. Long memory latencies test that the stall is not released on the wrong acknowledge, which would let the processor take stale data or finish a write that has not reached memory.

// File: rtl/dmcache.sv
module dmcache #(
  parameter int ADDR_W = 32,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - 2 - IDX_W;
  localparam int WA_W  = ADDR_W - 2;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_WRITE, S_DONE} state_t;

  state_t            state_q;
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [31:0]       data_q [LINES];
  logic [WA_W-1:0]   pend_wa_q;
  logic [31:0]       pend_data_q;
  logic              pend_we_q;

  wire [IDX_W-1:0] idx   = cpu_addr[IDX_W+1:2];
  wire [TAG_W-1:0] tag   = cpu_addr[ADDR_W-1:IDX_W+2];
  wire             hit   = valid_q[idx] && (tag_q[idx] == tag);
  wire [IDX_W-1:0] p_idx = pend_wa_q[IDX_W-1:0];
  wire [TAG_W-1:0] p_tag = pend_wa_q[WA_W-1:IDX_W];
  wire             unused_offset = ^cpu_addr[1:0];

  assign cpu_rdata = data_q[idx];
  assign cpu_stall = cpu_req && (state_q != S_DONE) &&
                     !((state_q == S_IDLE) && hit && !cpu_we);
  assign mem_req   = (state_q == S_FILL) || (state_q == S_WRITE);
  assign mem_we    = (state_q == S_WRITE);
  assign mem_addr  = {pend_wa_q, 2'b00};
  assign mem_wdata = pend_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      valid_q     <= '0;
      pend_wa_q   <= '0;
      pend_data_q <= '0;
      pend_we_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE:
          if (cpu_req && (!hit || cpu_we)) begin
            pend_wa_q   <= cpu_addr[ADDR_W-1:2];
            pend_data_q <= cpu_wdata;
            pend_we_q   <= cpu_we;
            state_q     <= hit ? S_WRITE : S_FILL;
          end
        S_FILL:
          if (mem_ack) begin
            valid_q[p_idx] <= 1'b1;
            state_q        <= pend_we_q ? S_WRITE : S_IDLE;
          end
        S_WRITE:
          if (mem_ack) state_q <= S_DONE;
        default:
          state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == S_FILL && mem_ack) begin
      tag_q[p_idx]  <= p_tag;
      data_q[p_idx] <= mem_rdata;
    end else if (state_q == S_WRITE && mem_ack) begin
      data_q[p_idx] <= pend_data_q;
    end
  end
endmodule

// File: rtl/dmcache_chk.sv
module dmcache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_stall,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack
);
  // R2
  read_done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && !cpu_stall) |-> !mem_req);

  // R3
  fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ack && mem_req && !mem_we) |=> (!cpu_req || cpu_we || !cpu_stall));

  // R6
  write_ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ack && mem_req && mem_we) |=> !cpu_stall);

  // R7
  stall_during_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && cpu_req) |-> cpu_stall);

  // R8
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

bind dmcache dmcache_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/dmcache_test.sv
`timescale 1ns/1ps
module dmcache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int n_chk = 0, n_bad = 0;
  int lat = 0, cnt = 0, n_rd = 0, n_wr = 0, hold_err = 0, cycles = 0;
  logic        pend = 1'b0;
  logic [31:0] p_addr = '0, p_data = '0;
  logic        p_we = 1'b0;
  logic [31:0] store [256];

  always #2 clk = ~clk;

  dmcache uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  function automatic logic [31:0] init_word(int i);
    return 32'h1000_0000 + i * 32'h0101;
  endfunction

  // memory model: ack after lat+1 edges of request, one-cycle pulse
  always @(posedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
      cnt     <= 0;
      if (mem_we) begin
        store[mem_addr[9:2]] <= mem_wdata;
        n_wr <= n_wr + 1;
      end else begin
        n_rd <= n_rd + 1;
      end
    end else if (mem_req) begin
      if (cnt == lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= store[mem_addr[9:2]];
      end else begin
        cnt <= cnt + 1;
      end
    end
    if (pend && (!mem_req || mem_addr != p_addr || mem_we != p_we || mem_wdata != p_data))
      hold_err <= hold_err + 1;
    pend   <= mem_req && !mem_ack;
    p_addr <= mem_addr;
    p_we   <= mem_we;
    p_data <= mem_wdata;
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL R7 watchdog: actual hung run, expected completion");
      summary();
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(logic we, logic [31:0] addr, logic [31:0] wd,
                        output logic [31:0] rd, output int cyc);
    bit done = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    cyc = 0;
    while (!done) begin
      #1;
      if (!cpu_stall) begin rd = cpu_rdata; done = 1; end
      else begin @(negedge clk); cyc++; end
    end
    @(posedge clk); #1;
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] rd; int cyc, r0;
    #1;
    chk("R1 idle stall", {31'b0, cpu_stall}, 32'd0);
    chk("R1 idle mem_req", {31'b0, mem_req}, 32'd0);
    lat = 0; r0 = n_rd;
    access(1'b0, 32'h40, '0, rd, cyc);
    chk("R1 first read misses", cyc, 3);
    chk("R3 fill data", rd, init_word(16));
    chk("R3 one memory read", n_rd - r0, 1);
  endtask

  task automatic t_hit();
    logic [31:0] rd; int cyc, r0;
    r0 = n_rd;
    access(1'b0, 32'h40, '0, rd, cyc);
    chk("R2 hit no stall", cyc, 0);
    chk("R2 hit data", rd, init_word(16));
    access(1'b0, 32'h43, '0, rd, cyc);
    chk("R8 byte offset hit stall", cyc, 0);
    chk("R8 byte offset hit data", rd, init_word(16));
    chk("R2 no memory reads", n_rd - r0, 0);
  endtask

  task automatic t_offset_miss();
    logic [31:0] rd; int cyc;
    access(1'b0, 32'h105, '0, rd, cyc);
    chk("R8 unaligned miss data", rd, init_word(32'h41));
    access(1'b0, 32'h106, '0, rd, cyc);
    chk("R8 same word hits", cyc, 0);
  endtask

  task automatic t_conflict();
    logic [31:0] rd; int cyc;
    access(1'b0, 32'h80, '0, rd, cyc);
    chk("R4 alias misses", cyc, 3);
    chk("R4 alias data", rd, init_word(32));
    access(1'b0, 32'h40, '0, rd, cyc);
    chk("R4 evicted word misses", cyc, 3);
    chk("R4 evicted word data", rd, init_word(16));
  endtask

  task automatic t_latency();
    logic [31:0] rd; int cyc;
    lat = 5;
    access(1'b0, 32'h88, '0, rd, cyc);
    chk("R7 slow miss stall cycles", cyc, 8);
    chk("R3 slow miss data", rd, init_word(34));
    lat = 0;
  endtask

  task automatic t_write_hit();
    logic [31:0] rd; int cyc, r0, w0;
    lat = 2; r0 = n_rd; w0 = n_wr;
    access(1'b1, 32'h40, 32'hDEAD_BEEF, rd, cyc);
    chk("R5 write hit stall cycles", cyc, 5);
    chk("R5 memory written", store[16], 32'hDEAD_BEEF);
    chk("R5 one write", n_wr - w0, 1);
    chk("R5 no read", n_rd - r0, 0);
    access(1'b0, 32'h40, '0, rd, cyc);
    chk("R5 read back hits", cyc, 0);
    chk("R5 read back data", rd, 32'hDEAD_BEEF);
    lat = 0;
  endtask

  task automatic t_write_miss();
    logic [31:0] rd; int cyc, r0, w0;
    lat = 1; r0 = n_rd; w0 = n_wr;
    access(1'b1, 32'h300, 32'hCAFE_F00D, rd, cyc);
    chk("R6 write miss stall cycles", cyc, 7);
    chk("R6 fill read", n_rd - r0, 1);
    chk("R6 write issued", n_wr - w0, 1);
    chk("R6 memory written", store[192], 32'hCAFE_F00D);
    access(1'b0, 32'h300, '0, rd, cyc);
    chk("R6 line allocated", cyc, 0);
    chk("R6 line data", rd, 32'hCAFE_F00D);
    lat = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) store[i] = init_word(i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_hit();
    t_offset_miss();
    t_conflict();
    t_latency();
    t_write_hit();
    t_write_miss();
    chk("R9 request held until ack", hold_err, 0);
    summary();
  end
endmodule